// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block drives the command line of an SD or MMC card for a single command at a time and collects the card's reply. Software first loads a 32-bit argument, then writes a command word. That write launches the transaction. The engine shifts out a 48-bit command frame, protected by CRC7, one bit per card clock. It then watches the line for the card's start bit. The reply is either a 48-bit or a 136-bit frame, and it is captured into four 32-bit response registers.

Completion sets exactly one of three write-1-to-clear flags: ready, timeout or response CRC error. Two busy bits in a status register tell software when the next command may be written. The card clock is a strobe produced from the system clock by a fixed divider. The block samples the incoming line on that strobe and changes its outgoing bit on it.

Register word addresses: 0 argument, 1 command word (read back), 2 status, 3 interrupt flags, 4 to 7 response words 0 to 3.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, every register reads 0, `cmd_oe` is low and `cmd_out` is high.
- R2: A write to the command word (address 1) while the block is idle sends a 48-bit frame on `cmd_out`, one bit per `card_strobe` and most significant bit first. The frame is a 0 start bit, a 1 direction bit, the opcode from command bits [5:0], the 32-bit argument, a CRC7 (x^7+x^3+1, zero seed) over those first 40 bits, and a 1 end bit. `cmd_oe` is high for exactly those 48 strobes.
- R3: Status bit 1 (command busy) is set from the command write until the completion flag appears. Status bit 0 (controller busy) is also set through a further 8 strobes of recovery after completion.
- R4: A command-word write while either status bit is set is ignored. The command word reads back unchanged, and no further frame is sent.
- R5: Command bits [9:7] select the reply. Code 0 means no reply, and the ready flag is set right after the end bit. Codes 1 and 7 mean a 48-bit reply with CRC check. Code 2 means a 136-bit reply without check. Code 3 means a 48-bit reply without check. All other command-word bits have no effect.
- R6: After a 48-bit reply, response word 0 holds reply bits [39:8] and words 1 to 3 read 0.
- R7: After a 136-bit reply, reply bits [127:0] are spread over the response words. Word 3 holds [127:96] and word 0 holds [31:0].
- R8: The reply start bit (a 0) is accepted on any of the 64 strobes that follow the end-bit strobe. If none arrives, interrupt bit 9 (timeout) is set instead of ready.
- R9: For checked codes, a reply CRC7 over reply bits [47:8] that differs from bits [7:1] sets interrupt bit 10 instead of bit 8. Codes 2 and 3 never set bit 10.
- R10: Writing 1 to interrupt bit 8, 9 or 10 clears it. A 0, or any other bit, leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| card_strobe | output | 1 | One-cycle card clock strobe; line bits change and are sampled on it |
| cmd_out | output | 1 | Outgoing command line bit |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Incoming command line level |

## Verification
The bench builds the engine with a strobe divider of 3, so that every bit spans several system cycles and a register write can fall between strobes. It keeps the default 64-strobe reply window and the 8-strobe recovery. With these settings the reply-window edge can be reached directly: a start bit on strobe 64 is accepted, and one on strobe 65 times out. A card model in the bench supplies 48- and 136-bit replies with good and corrupted CRC. Random opcodes, arguments, reply codes, delays and junk in the unused command fields are mixed with directed cases for busy-time writes and flag clearing.

// File: rtl/sdcmd_pkg.sv
// Shared constants, types and the CRC7 function for the command line engine.
// Assumes the CRC seed is zero and data enters most significant bit first.
package sdcmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int CAPT_BITS  = 128;

    localparam logic [2:0] A_ARG  = 3'd0;
    localparam logic [2:0] A_CMD  = 3'd1;
    localparam logic [2:0] A_STS  = 3'd2;
    localparam logic [2:0] A_INT  = 3'd3;

    localparam int FLAG_LSB = 8;
    localparam int N_FLAGS  = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TX, ST_WAIT, ST_RX, ST_FIN, ST_RECOV
    } eng_state_t;

    typedef enum logic [1:0] { RSP_NONE, RSP_SHORT, RSP_LONG } rsp_len_t;

    // Completion event; exactly one field is set per command.
    typedef struct packed {
        logic crc_err;
        logic tmo;
        logic ready;
    } cmd_event_t;

    function automatic rsp_len_t rsp_len_of(input logic [2:0] code);
        if (code == 3'd0)      return RSP_NONE;
        else if (code == 3'd2) return RSP_LONG;
        else                   return RSP_SHORT;
    endfunction

    function automatic logic rsp_crc_on(input logic [2:0] code);
        return (code != 3'd0) && (code != 3'd2) && (code != 3'd3);
    endfunction

    function automatic logic [6:0] crc7_calc(input logic [39:0] d);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_strobe.sv
// Card clock strobe generator: a one-cycle pulse every CLK_DIV system cycles.
// Assumes CLK_DIV >= 2.
module sdcmd_strobe #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Free-running divider counter, wraps at CLK_DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (cnt_q == CW'(CLK_DIV-1))  cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    assign strobe = (cnt_q == CW'(CLK_DIV-1));
endmodule

// File: rtl/sdcmd_fsm.sv
// Command line sequencer: serialises the command frame, waits for the reply
// start bit within RESP_WAIT strobes, shifts the reply in, judges its CRC and
// holds a RECOV_TICKS-strobe recovery gap. Assumes start only arrives in idle.
module sdcmd_fsm
    import sdcmd_pkg::*;
#(
    parameter int RESP_WAIT   = 64,
    parameter int RECOV_TICKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe,
    input  logic                 start,
    input  logic [5:0]           op,
    input  logic [2:0]           code,
    input  logic [31:0]          arg,
    input  logic                 cmd_in,
    output logic                 cmd_out,
    output logic                 cmd_oe,
    output logic                 cmd_busy,
    output logic                 ctl_busy,
    output logic                 done,
    output cmd_event_t           evt,
    output logic                 rsp_we,
    output logic                 rsp_long,
    output logic [CAPT_BITS-1:0] rsp_bits
);
    localparam int WW = (RESP_WAIT > 2) ? $clog2(RESP_WAIT) : 1;
    localparam int RW = (RECOV_TICKS > 2) ? $clog2(RECOV_TICKS) : 1;

    eng_state_t             state_q;
    logic [FRAME_BITS-1:0]  txsr_q;
    logic [7:0]             bcnt_q;
    logic [WW-1:0]          wcnt_q;
    logic [RW-1:0]          rcv_q;
    logic [2:0]             code_q;
    logic [CAPT_BITS-1:0]   rxsr_q;
    logic                   wait_expire;
    logic                   crc_bad;

    assign wait_expire = (state_q == ST_WAIT) && strobe && cmd_in &&
                         (wcnt_q == WW'(RESP_WAIT-1));
    assign crc_bad     = rsp_crc_on(code_q) &&
                         (crc7_calc(rxsr_q[47:8]) != rxsr_q[7:1]);

    // Main sequencer: one bit moves per strobe in the line-facing states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            txsr_q  <= '0;
            bcnt_q  <= '0;
            wcnt_q  <= '0;
            rcv_q   <= '0;
            code_q  <= '0;
            rxsr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    txsr_q  <= {2'b01, op, arg, crc7_calc({2'b01, op, arg}), 1'b1};
                    bcnt_q  <= 8'(FRAME_BITS-1);
                    code_q  <= code;
                    state_q <= ST_TX;
                end
                ST_TX: if (strobe) begin
                    if (bcnt_q == 8'd0) begin
                        wcnt_q  <= '0;
                        rxsr_q  <= '0;
                        state_q <= (rsp_len_of(code_q) == RSP_NONE) ? ST_FIN : ST_WAIT;
                    end else begin
                        txsr_q <= {txsr_q[FRAME_BITS-2:0], 1'b1};
                        bcnt_q <= bcnt_q - 8'd1;
                    end
                end
                ST_WAIT: if (strobe) begin
                    if (!cmd_in) begin
                        rxsr_q  <= {rxsr_q[CAPT_BITS-2:0], 1'b0};
                        bcnt_q  <= (rsp_len_of(code_q) == RSP_LONG) ?
                                   8'(LONG_BITS-1) : 8'(SHORT_BITS-1);
                        state_q <= ST_RX;
                    end else if (wait_expire) begin
                        rcv_q   <= '0;
                        state_q <= ST_RECOV;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_RX: if (strobe) begin
                    rxsr_q <= {rxsr_q[CAPT_BITS-2:0], cmd_in};
                    if (bcnt_q == 8'd1) state_q <= ST_FIN;
                    else                bcnt_q  <= bcnt_q - 8'd1;
                end
                ST_FIN: begin
                    rcv_q   <= '0;
                    state_q <= ST_RECOV;
                end
                ST_RECOV: if (strobe) begin
                    if (rcv_q == RW'(RECOV_TICKS-1)) state_q <= ST_IDLE;
                    else                              rcv_q   <= rcv_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion event and response hand-off towards the register file.
    always_comb begin
        evt      = '0;
        done     = 1'b0;
        rsp_we   = 1'b0;
        if (wait_expire) begin
            done    = 1'b1;
            evt.tmo = 1'b1;
        end else if (state_q == ST_FIN) begin
            done   = 1'b1;
            rsp_we = (rsp_len_of(code_q) != RSP_NONE);
            if (rsp_we && crc_bad) evt.crc_err = 1'b1;
            else                   evt.ready   = 1'b1;
        end
    end

    assign rsp_long = (rsp_len_of(code_q) == RSP_LONG);
    assign rsp_bits = rxsr_q;
    assign cmd_oe   = (state_q == ST_TX);
    assign cmd_out  = (state_q == ST_TX) ? txsr_q[FRAME_BITS-1] : 1'b1;
    assign cmd_busy = (state_q == ST_TX) || (state_q == ST_WAIT) ||
                      (state_q == ST_RX) || (state_q == ST_FIN);
    assign ctl_busy = (state_q != ST_IDLE);
endmodule

// File: rtl/sdcmd_regs.sv
// Host register file: argument, command word, status, write-1-to-clear flags
// and four response words. Assumes one write per cycle; a set wins over a clear.
module sdcmd_regs
    import sdcmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [2:0]           rd_addr,
    output logic [31:0]          rd_data,
    input  logic                 cmd_busy,
    input  logic                 ctl_busy,
    input  logic                 done,
    input  cmd_event_t           evt,
    input  logic                 rsp_we,
    input  logic                 rsp_long,
    input  logic [CAPT_BITS-1:0] rsp_bits,
    output logic                 start,
    output logic [5:0]           op,
    output logic [2:0]           code,
    output logic [31:0]          arg
);
    logic [31:0]        arg_q;
    logic [31:0]        cmd_q;
    logic               start_q;
    logic [N_FLAGS-1:0] flag_q;
    logic [N_FLAGS-1:0] flag_set;
    logic [3:0][31:0]   rsp_q;
    logic               cmd_take;

    assign cmd_take = wr_en && (wr_addr == A_CMD) && !ctl_busy && !start_q;
    assign flag_set = done ? {evt.crc_err, evt.tmo, evt.ready} : '0;

    // Argument and command word capture; a taken command word fires start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q   <= '0;
            cmd_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= cmd_take;
            if (wr_en && (wr_addr == A_ARG)) arg_q <= wr_data;
            if (cmd_take)                    cmd_q <= wr_data;
        end
    end

    // One sticky flag per completion kind, cleared by writing 1 to its bit.
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)           flag_q[g] <= 1'b0;
            else if (flag_set[g]) flag_q[g] <= 1'b1;
            else if (wr_en && (wr_addr == A_INT) && wr_data[FLAG_LSB+g])
                                  flag_q[g] <= 1'b0;
        end
    end

    // Response words loaded on reply completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else if (rsp_we) begin
            if (rsp_long) begin
                rsp_q <= rsp_bits;
            end else begin
                rsp_q    <= '0;
                rsp_q[0] <= rsp_bits[39:8];
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        if (rd_addr[2]) begin
            rd_data = rsp_q[rd_addr[1:0]];
        end else begin
            unique case (rd_addr[1:0])
                2'd0:    rd_data = arg_q;
                2'd1:    rd_data = cmd_q;
                2'd2:    rd_data = {30'd0, cmd_busy | start_q, ctl_busy | start_q};
                default: rd_data = {21'd0, flag_q, 8'd0};
            endcase
        end
    end

    assign start = start_q;
    assign op    = cmd_q[5:0];
    assign code  = cmd_q[9:7];
    assign arg   = arg_q;
endmodule

// File: rtl/sdcmd_engine.sv
// Top of the command line engine: strobe divider, register file, sequencer.
// Assumes cmd_in is already synchronised to clk.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int RESP_WAIT   = 64,
    parameter int RECOV_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        card_strobe,
    output logic        cmd_out,
    output logic        cmd_oe,
    input  logic        cmd_in
);
    logic                 start_w, cmd_busy_w, ctl_busy_w, done_w;
    logic                 rsp_we_w, rsp_long_w;
    logic [5:0]           op_w;
    logic [2:0]           code_w;
    logic [31:0]          arg_w;
    logic [CAPT_BITS-1:0] rsp_bits_w;
    cmd_event_t           evt_w;

    sdcmd_strobe #(.CLK_DIV(CLK_DIV)) u_strobe (
        .clk(clk), .rst_n(rst_n), .strobe(card_strobe)
    );

    sdcmd_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_busy(cmd_busy_w), .ctl_busy(ctl_busy_w),
        .done(done_w), .evt(evt_w),
        .rsp_we(rsp_we_w), .rsp_long(rsp_long_w), .rsp_bits(rsp_bits_w),
        .start(start_w), .op(op_w), .code(code_w), .arg(arg_w)
    );

    sdcmd_fsm #(.RESP_WAIT(RESP_WAIT), .RECOV_TICKS(RECOV_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(card_strobe),
        .start(start_w), .op(op_w), .code(code_w), .arg(arg_w),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_busy(cmd_busy_w), .ctl_busy(ctl_busy_w),
        .done(done_w), .evt(evt_w),
        .rsp_we(rsp_we_w), .rsp_long(rsp_long_w), .rsp_bits(rsp_bits_w)
    );
endmodule

// File: rtl/sdcmd_engine_chk.sv
// Protocol checker for the command line engine, bound into the top.
module sdcmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_oe,
    input logic       cmd_out,
    input logic       cmd_busy,
    input logic       ctl_busy,
    input logic       start,
    input logic       done,
    input logic [2:0] evt,
    input logic [2:0] code
);
    assert_oe_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> cmd_busy);

    assert_busy_nest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |-> ctl_busy);

    assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);

    assert_end_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cmd_oe);

    assert_idle_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !$past(ctl_busy));

    assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot(evt));

    assert_no_crc_unchecked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (code == 3'd2 || code == 3'd3)) |-> !evt[2]);
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .cmd_out(cmd_out),
    .cmd_busy(cmd_busy_w), .ctl_busy(ctl_busy_w), .start(start_w),
    .done(done_w), .evt(evt_w), .code(code_w)
);

// File: tb/sdcmd_engine_bench.sv
`timescale 1ns/1ps
module sdcmd_engine_bench;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        card_strobe, cmd_out, cmd_oe;
    logic        cmd_in = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sdcmd_engine #(.CLK_DIV(DIV), .RESP_WAIT(64), .RECOV_TICKS(8)) u_sdcmd_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .card_strobe(card_strobe), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_in(cmd_in)
    );

    function automatic logic [6:0] bench_crc7(input logic [39:0] d);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic top = r[6] ^ d[i];
            r = {r[5:0], 1'b0} ^ (top ? 7'b0001001 : 7'b0);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic run_cmd(input logic [5:0] op, input logic [31:0] arg,
                           input logic [2:0] code, input int delay, input bit bad,
                           input bit poke_tx, input bit poke_rec, input bit keep_int);
        logic [135:0] rf;
        logic [39:0]  hd;
        logic [6:0]   cc;
        logic [47:0]  txv, txe;
        logic [31:0]  cw, s, v, e;
        int len, nb, k, guard, rc;
        bit fin, poked;
        rf = '0;
        len = (code == 3'd0) ? 0 : ((code == 3'd2) ? 136 : 48);
        if (len == 48) begin
            hd = {2'b00, 6'($urandom), 32'($urandom)};
            cc = bench_crc7(hd);
            if (bad) cc = cc ^ 7'h11;
            rf[47:0] = {hd, cc, 1'b1};
        end else if (len == 136) begin
            rf = {2'b00, 6'h3f, 32'($urandom), 32'($urandom), 32'($urandom),
                  31'($urandom), 1'b1};
        end
        txe = {2'b01, op, arg, bench_crc7({2'b01, op, arg}), 1'b1};
        cw = $urandom;
        cw[5:0] = op;
        cw[9:7] = code;
        reg_wr(3'd0, arg);
        reg_wr(3'd1, cw);
        nb = 0; k = 0; guard = 0; fin = 0; poked = 0; txv = '0;
        while (!fin && guard < 20000) begin
            @(negedge clk);
            guard++;
            wr_en = 1'b0;
            if (card_strobe) begin
                if (nb < 48) begin
                    if (cmd_oe) begin
                        txv = {txv[46:0], cmd_out};
                        nb++;
                    end
                end else begin
                    k++;
                    cmd_in = (k >= delay && k < delay + len) ? rf[len-1-(k-delay)] : 1'b1;
                end
            end
            if (poke_tx && nb == 10 && !poked) begin
                wr_en = 1'b1; wr_addr = 3'd1; wr_data = ~cw; poked = 1;
            end
            if (nb == 20 && card_strobe) begin
                reg_rd(3'd2, s);
                chk(s == 32'd3, "R3 busy bits mid-frame", 64'(s), 64'd3);
            end
            if (nb == 48) begin
                reg_rd(3'd2, s);
                if (!s[1]) fin = 1;
            end
        end
        cmd_in = 1'b1;
        chk(fin, "R2 command completed", 64'(fin), 64'd1);
        chk(txv == txe, "R2 command frame", 64'(txv), 64'(txe));
        // completion flag
        reg_rd(3'd3, v);
        if (len == 0)                           e = 32'h100;
        else if (delay > 64)                    e = 32'h200;
        else if (bad && code != 2 && code != 3) e = 32'h400;
        else                                    e = 32'h100;
        chk(v == e, (e == 32'h200) ? "R8 timeout flag" :
                    (e == 32'h400) ? "R9 crc flag" : "R5 ready flag", 64'(v), 64'(e));
        chk(s[0] == 1'b1, "R3 controller busy in recovery", 64'(s), 64'd1);
        // recovery window
        rc = 0; poked = 0;
        forever begin
            reg_rd(3'd2, s);
            if (!s[0]) break;
            if (card_strobe) rc++;
            if (poke_rec && rc == 3 && !poked) begin
                wr_en = 1'b1; wr_addr = 3'd1; wr_data = ~cw; poked = 1;
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
        wr_en = 1'b0;
        chk(rc == 8, "R3 recovery strobes", 64'(rc), 64'd8);
        reg_rd(3'd1, v);
        chk(v == cw, "R4 command word readback", 64'(v), 64'(cw));
        if (poke_rec) begin
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (cmd_oe) begin
                    chk(0, "R4 no frame after ignored write", 64'(cmd_oe), 64'd0);
                    break;
                end
            end
            reg_rd(3'd2, s);
            chk(s == 32'd0, "R4 idle after ignored write", 64'(s), 64'd0);
        end
        // response words
        if (len == 48 && delay <= 64) begin
            reg_rd(3'd4, v);
            chk(v == rf[39:8], "R6 short response word 0", 64'(v), 64'(rf[39:8]));
            for (int i = 5; i < 8; i++) begin
                reg_rd(3'(i), v);
                chk(v == 32'd0, "R6 upper words zero", 64'(v), 64'd0);
            end
        end else if (len == 136 && delay <= 64) begin
            for (int i = 0; i < 4; i++) begin
                reg_rd(3'(4 + i), v);
                chk(v == rf[32*i +: 32], "R7 long response word", 64'(v),
                    64'(rf[32*i +: 32]));
            end
        end
        if (!keep_int) begin
            reg_wr(3'd3, 32'h700);
            reg_rd(3'd3, v);
            chk(v == 32'd0, "R10 flags cleared", 64'(v), 64'd0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [2:0]  codes [5];
        codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd2; codes[3] = 3'd3; codes[4] = 3'd7;
        void'($urandom(32'h5d1c0de));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            reg_rd(3'(i), v);
            chk(v == 32'd0, "R1 register after reset", 64'(v), 64'd0);
        end
        chk(cmd_oe == 1'b0 && cmd_out == 1'b1, "R1 line idle", {62'd0, cmd_oe, cmd_out}, 64'd1);

        run_cmd(6'd0,  32'h0000_0000, 3'd0, 1,  0, 0, 0, 0); // R5 no reply
        run_cmd(6'd17, 32'hdead_beef, 3'd1, 1,  0, 0, 0, 0); // R6 fastest reply
        run_cmd(6'd13, 32'h1234_5678, 3'd1, 64, 0, 0, 0, 0); // R8 last accepted strobe
        run_cmd(6'd13, 32'h1234_5678, 3'd1, 65, 0, 0, 0, 0); // R8 timeout
        run_cmd(6'd12, 32'h0,         3'd7, 5,  1, 0, 0, 0); // R9 corrupted CRC
        run_cmd(6'd2,  32'hffff_ffff, 3'd2, 3,  1, 0, 0, 0); // R7 long, no check
        run_cmd(6'd1,  32'h40ff_8080, 3'd3, 7,  1, 0, 0, 0); // R9 R3-type no check
        run_cmd(6'd24, 32'h0000_1000, 3'd1, 4,  0, 1, 0, 0); // R4 write during frame
        run_cmd(6'd25, 32'h0000_2000, 3'd7, 9,  0, 0, 1, 0); // R4 write during recovery

        // R10 W1C: ready flag set, then partial writes
        run_cmd(6'd0, 32'h5, 3'd0, 1, 0, 0, 0, 1);
        reg_wr(3'd3, 32'hffff_f6ff);
        reg_rd(3'd3, v);
        chk(v == 32'h100, "R10 other bits do not clear", 64'(v), 64'h100);
        reg_wr(3'd3, 32'h0);
        reg_rd(3'd3, v);
        chk(v == 32'h100, "R10 zero write keeps flag", 64'(v), 64'h100);
        reg_wr(3'd3, 32'h100);
        reg_rd(3'd3, v);
        chk(v == 32'h0, "R10 one clears flag", 64'(v), 64'h0);

        for (int n = 0; n < 25; n++) begin
            run_cmd(6'($urandom), $urandom, codes[$urandom_range(0, 4)],
                    $urandom_range(1, 70), 1'($urandom), 0, 0, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule